// File: doc/BRIEF.md
# Gated Divided Clock Generator

This block derives one output clock from four free-running input clocks: two oscillators and two PLLs. A small control register, written and read on a separate bus clock, chooses the source and an optional even-ratio prescaler, and it turns the output on and off. A sleep-mask input from a power controller can also force the output off without touching the register.

Every start and stop of the output is timed by a falling edge of the selected source. A start or stop therefore never leaves a sliver of a pulse on the output. When the output is stopped, the prescaler is cleared, so each restart begins from a known phase. The status bit keeps reading 1 after software clears the enable bit, and turns to 0 only once the output has stopped. Software uses this bit to know when it may safely change the source or the divider.

Top module: `gclk_gen`

## Requirements
- R1: In reset (rst high, synchronous), every register field clears, rd_data reads 0 and gclk stays low.
- R2: The register layout is: bit 0 enable, bit 1 PLL-pair select, bit 2 member select, bit 3 divide-enable, bits 11:4 divide factor D. Source index {bit1,bit2} picks src_clks[index]: 0 oscillator 0, 1 oscillator 1, 2 PLL 0, 3 PLL 1.
- R3: With divide-enable 0, gclk follows the selected source with the same period and high time.
- R4: With divide-enable 1, gclk is high for D+1 source periods and low for D+1 source periods, giving a period of 2*(D+1) source periods, for every D from 0 to 255.
- R5: gclk produces no rising edge while the enable bit is 0 or sleep_mask is 1.
- R6: Clearing the enable bit or raising sleep_mask forces gclk low at the first falling edge of the selected source after the event.
- R7: rd_data bit 0 reads 1 while the enable bit is set or the output is still running. After a write of 0, it keeps reading 1 until the stop has taken place, and then reads 0.
- R8: While a disable is pending (enable written 0, bit 0 still reading 1), writes leave the select, divide-enable and divide fields unchanged.
- R9: The output starts on a falling edge of the source with the prescaler cleared, so the first high phase after enabling or leaving sleep has full length.
- R10: gclk never shows a high pulse shorter than half a period of the selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 12 | Register write value |
| rd_data | output | 12 | Registered readback: fields, with the status in bit 0 |
| src_clks | input | 4 | Source clocks: osc0, osc1, pll0, pll1 at index 0..3 |
| sleep_mask | input | 1 | High forces the output off |
| gclk | output | 1 | Generated clock |

## Verification
The bench times the first high phase after enabling and after leaving sleep. A design that starts the prescaler mid-count, or that releases the gate on a rising edge, shows a short first pulse. It times the stop against the next source falling edge, and checks that the status does not drop early. A status that only mirrors the written bit reads 0 while the clock still runs. It writes new settings during a pending disable and reads them back afterwards, which catches a register that does not lock those fields. The largest divide factor and factor 0 are run in divided mode, and randomly chosen configurations cover all four sources. A monitor flags any high pulse shorter than half a source period.

// File: rtl/gclk_pkg.sv
`timescale 1ns/1ps
package gclk_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_SRC = 1 << SEL_W;
  localparam int DIV_W_DEFAULT = 8;

  // register bit positions
  localparam int B_EN    = 0;
  localparam int B_PLL   = 1;
  localparam int B_IDX   = 2;
  localparam int B_DIVEN = 3;
  localparam int B_DIV   = 4;

  typedef enum logic [SEL_W-1:0] {
    SRC_OSC0 = 2'd0,
    SRC_OSC1 = 2'd1,
    SRC_PLL0 = 2'd2,
    SRC_PLL1 = 2'd3
  } src_e;
endpackage

// File: rtl/gclk_sync.sv
`timescale 1ns/1ps
module gclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gclk_regs.sv
`timescale 1ns/1ps
module gclk_regs
  import gclk_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEFAULT,
  localparam int DATA_W = DIV_W + B_DIV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              run_s,
  output logic              en_q,
  output src_e              src_sel,
  output logic              div_en_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [DATA_W-1:0] rd_data
);
  logic pending;
  logic status;

  assign pending = !en_q && run_s;
  assign status  = en_q || run_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      src_sel  <= SRC_OSC0;
      div_en_q <= 1'b0;
      div_q    <= '0;
      rd_data  <= '0;
    end else begin
      if (wr_en) begin
        en_q <= wr_data[B_EN];
        if (!pending) begin
          src_sel  <= src_e'({wr_data[B_PLL], wr_data[B_IDX]});
          div_en_q <= wr_data[B_DIVEN];
          div_q    <= wr_data[B_DIV +: DIV_W];
        end
      end
      rd_data <= {div_q, div_en_q, src_sel[0], src_sel[1], status};
    end
  end

  // R1: reset clears the enable and the divider
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!en_q && div_q == '0 && !div_en_q));

  // R8: settings locked while a disable is pending
  a_r8_fields_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pending) |=> ($stable(div_q) && $stable(div_en_q) && $stable(src_sel)));

  // R7: a set enable bit always reads back as running
  a_r7_status_high: assert property (@(posedge clk) disable iff (rst)
    en_q |=> rd_data[B_EN]);
endmodule

// File: rtl/gclk_src_mux.sv
`timescale 1ns/1ps
module gclk_src_mux
  import gclk_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic [SEL_W-1:0]   sel,
  output logic               src_clk
);
  logic [NUM_SRC-1:0] pick;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pick
    assign pick[i] = src_clks[i] & (sel == SEL_W'(i));
  end

  assign src_clk = |pick;
endmodule

// File: rtl/gclk_gate_div.sv
`timescale 1ns/1ps
module gclk_gate_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst,
  input  logic             req_i,
  input  logic             div_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             run_o,
  output logic             gclk_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tog_q;

  // gate state changes only while the source is low
  always_ff @(negedge clk_i) begin
    if (rst) run_o <= 1'b0;
    else     run_o <= req_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst || !run_o || !div_en_i) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else if (cnt_q == div_i) begin
      cnt_q <= '0;
      tog_q <= ~tog_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign gclk_o = run_o & (div_en_i ? tog_q : clk_i);

  // R6: a dropped request stops the gate at that falling edge
  a_r6_stop_on_fall: assert property (@(negedge clk_i) disable iff (rst)
    !req_i |=> !run_o);

  // R9: a stopped gate leaves the prescaler cleared
  a_r9_prescaler_clear: assert property (@(posedge clk_i) disable iff (rst)
    !run_o |=> (cnt_q == '0 && !tog_q));

  // R4: the count never passes the divide factor
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (rst)
    (run_o && div_en_i) |-> (cnt_q <= div_i));
endmodule

// File: rtl/gclk_gen.sv
`timescale 1ns/1ps
module gclk_gen
  import gclk_pkg::*;
#(
  parameter int DIV_W  = DIV_W_DEFAULT,
  localparam int DATA_W = DIV_W + B_DIV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic               sleep_mask,
  output logic               gclk
);
  logic             en_q;
  src_e             src_sel;
  logic             div_en_q;
  logic [DIV_W-1:0] div_q;
  logic             run;
  logic             run_s;
  logic             src_clk;
  logic             req;

  gclk_regs #(.DIV_W(DIV_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .run_s    (run_s),
    .en_q     (en_q),
    .src_sel  (src_sel),
    .div_en_q (div_en_q),
    .div_q    (div_q),
    .rd_data  (rd_data)
  );

  gclk_src_mux u_mux (
    .src_clks (src_clks),
    .sel      (src_sel),
    .src_clk  (src_clk)
  );

  assign req = en_q & ~sleep_mask;

  gclk_gate_div #(.DIV_W(DIV_W)) u_gate (
    .clk_i    (src_clk),
    .rst      (rst),
    .req_i    (req),
    .div_en_i (div_en_q),
    .div_i    (div_q),
    .run_o    (run),
    .gclk_o   (gclk)
  );

  gclk_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (run),
    .q   (run_s)
  );
endmodule

// File: tb/gclk_gen_test.sv
`timescale 1ns/1ps
module gclk_gen_test;
  localparam int DIV_W  = 8;
  localparam int DATA_W = DIV_W + 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic osc0 = 1'b0, osc1 = 1'b0, pll0 = 1'b0, pll1 = 1'b0;
  logic              sleep_mask = 1'b0;
  logic              gclk;

  int total = 0;
  int fails = 0;
  int rise_cnt = 0;
  int runt_cnt = 0;
  real cur_half = 1000.0;
  real t_hi = 0.0;

  gclk_gen #(.DIV_W(DIV_W)) uut (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .src_clks   ({pll1, pll0, osc1, osc0}),
    .sleep_mask (sleep_mask),
    .gclk       (gclk)
  );

  always #10  clk  = ~clk;
  always #150 osc0 = ~osc0;
  always #110 osc1 = ~osc1;
  always #50  pll0 = ~pll0;
  always #40  pll1 = ~pll1;

  always @(posedge gclk) begin
    rise_cnt++;
    t_hi = $realtime;
  end
  always @(negedge gclk) begin
    if (!rst && ($realtime - t_hi) < cur_half - 0.01) runt_cnt++;
  end

  function automatic real src_period(input int s);
    case (s)
      0: return 300.0;
      1: return 220.0;
      2: return 100.0;
      default: return 80.0;
    endcase
  endfunction

  function automatic real exp_high(input int s, input bit de, input int d);
    return de ? src_period(s) * (d + 1) : src_period(s) / 2.0;
  endfunction

  function automatic real exp_per(input int s, input bit de, input int d);
    return de ? 2.0 * src_period(s) * (d + 1) : src_period(s);
  endfunction

  function automatic logic [DATA_W-1:0] pack(input bit en, input int s, input bit de, input int d);
    logic [1:0] sv;
    sv = 2'(s);
    return {8'(d), de, sv[0], sv[1], en};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_t(input string req, input string what, input real act, input real exp);
    chk((act > exp - 0.01) && (act < exp + 0.01), req, what, act, exp);
  endtask

  task automatic wr(input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_src_neg(input int s);
    case (s)
      0: @(negedge osc0);
      1: @(negedge osc1);
      2: @(negedge pll0);
      default: @(negedge pll1);
    endcase
  endtask

  task automatic wait_stopped(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!rd_data[0]) begin
        ok = 1'b1;
        return;
      end
    end
  endtask

  task automatic stop_cfg(input int s, input bit de, input int d, input bit try_lock);
    bit ok;
    int r;
    wait_src_neg(s);
    wr(pack(1'b0, s, de, d));
    @(negedge clk);
    chk(rd_data[0] == 1'b1, "R7", "status right after disable", real'(rd_data[0]), 1.0);
    if (try_lock) wr(pack(1'b0, (s + 1) % 4, !de, (d + 3) % 256));
    wait_src_neg(s);
    #1;
    r = rise_cnt;
    chk(gclk == 1'b0, "R6", "gclk after first source fall", real'(gclk), 0.0);
    wait_stopped(ok);
    chk(ok, "R7", "status reaches 0", real'(ok), 1.0);
    repeat (3) wait_src_neg(s);
    chk(rise_cnt == r, "R5", "rising edges after stop", real'(rise_cnt - r), 0.0);
    if (try_lock)
      chk(rd_data == pack(1'b0, s, de, d), "R8", "fields after locked write",
          real'(rd_data), real'(pack(1'b0, s, de, d)));
  endtask

  task automatic run_cfg(input int s, input bit de, input int d, input bit try_lock);
    real t0, t1, t2, t3, t4;
    string rq;
    rq = de ? "R4" : "R3";
    cur_half = src_period(s) / 2.0;
    wr(pack(1'b1, s, de, d));
    @(posedge gclk); t0 = $realtime;
    @(negedge gclk); t1 = $realtime;
    @(posedge gclk); t2 = $realtime;
    @(negedge gclk); t3 = $realtime;
    @(posedge gclk); t4 = $realtime;
    chk_t("R9", "first high phase", t1 - t0, exp_high(s, de, d));
    chk_t(rq, "high phase (R2 source)", t3 - t2, exp_high(s, de, d));
    chk_t(rq, "period (R2 source)", t4 - t2, exp_per(s, de, d));
    stop_cfg(s, de, d, try_lock);
  endtask

  initial begin
    #3_000_000;
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (5) @(negedge clk);
    @(negedge clk);
    chk(rd_data == '0, "R1", "rd_data in reset", real'(rd_data), 0.0);
    chk(gclk == 1'b0, "R1", "gclk in reset", real'(gclk), 0.0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_data == '0, "R1", "rd_data after reset", real'(rd_data), 0.0);

    // all four sources undivided, R2/R3
    for (int s = 0; s < 4; s++) run_cfg(s, 1'b0, 0, 1'b0);
    // divide boundaries, R4
    run_cfg(3, 1'b1, 0, 1'b0);
    run_cfg(3, 1'b1, 255, 1'b0);
    // pending-disable lock, R8
    run_cfg(0, 1'b1, 2, 1'b1);

    // sleep mask: stop, hold off, restart with full pulse (R5, R6, R9)
    begin
      int r;
      real a, b;
      cur_half = src_period(1) / 2.0;
      wr(pack(1'b1, 1, 1'b1, 1));
      repeat (3) @(posedge gclk);
      @(negedge clk);
      sleep_mask = 1'b1;
      wait_src_neg(1);
      #1;
      chk(gclk == 1'b0, "R6", "gclk after sleep edge", real'(gclk), 0.0);
      r = rise_cnt;
      repeat (6) wait_src_neg(1);
      chk(rise_cnt == r, "R5", "edges during sleep", real'(rise_cnt - r), 0.0);
      @(negedge clk);
      sleep_mask = 1'b0;
      @(posedge gclk); a = $realtime;
      @(negedge gclk); b = $realtime;
      chk_t("R9", "first high after sleep", b - a, exp_high(1, 1'b1, 1));
      stop_cfg(1, 1'b1, 1, 1'b0);
    end

    // random configurations
    for (int k = 0; k < 8; k++) begin
      int s, d;
      bit de;
      s  = int'($urandom % 4);
      de = 1'($urandom % 2);
      d  = int'($urandom % 6);
      run_cfg(s, de, d, 1'($urandom % 2));
    end

    chk(runt_cnt == 0, "R10", "short high pulses", real'(runt_cnt), 0.0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule